// File: doc/BRIEF.md
# Two-Bank Parity-Interleaved FFT Operand Cache

This block is the small local store that sits between the main memory and the butterfly of a cache-based FFT engine. Each cycle the butterfly needs two operands read and two results written. A true four-port memory would be costly, so the store is built from two register banks, each with one read and one write per cycle. Even addresses live in one bank and odd addresses in the other. A crossbar steers each of the two read ports and each of the two write ports to the bank that its address parity selects.

The FFT schedule is expected to split every pair of reads and every pair of writes across the two banks. When the schedule breaks that rule, the block raises a conflict flag in the same cycle. Port A keeps the bank and the port B access is dropped. Each stored word is a complex sample, with 13 bits per real component by default. The entry count is a parameter, with 32 as the default.

Top module: `dual_bank_cache`

## Requirements
- R1: While reset is asserted, every stored entry and both read data outputs are cleared to zero, and after reset any address reads back as zero until it is written.
- R2: Address bit 0 selects the bank (0 = even bank, 1 = odd bank), and the remaining upper bits select the entry within that bank. A word written through either write port reads back at the same address through either read port.
- R3: A read issued in one cycle presents its data on the read data output right after the next rising clock edge, so the read latency is one cycle.
- R4: Two reads to addresses of different parity in the same cycle are both served, and the conflict flag stays low.
- R5: Two writes to addresses of different parity in the same cycle are both stored.
- R6: A read and a write to the same address in the same cycle return the value that was stored before the write.
- R7: When both read ports are enabled and their addresses have equal parity, the conflict flag is high in that cycle. Port A is served, and the port B read data output keeps its previous value.
- R8: When both write ports are enabled and their addresses have equal parity, the conflict flag is high in that cycle. Only the port A write is stored, and port B's write changes no entry.
- R9: A read port that is not enabled holds its read data output unchanged.
- R10: The conflict flag is low in any cycle where no two enabled reads and no two enabled writes share a parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| rdEnA | input | 1 | Read request on port A |
| rdAddrA | input | ADDR_W | Read address on port A |
| rdEnB | input | 1 | Read request on port B |
| rdAddrB | input | ADDR_W | Read address on port B |
| wrEnA | input | 1 | Write request on port A |
| wrAddrA | input | ADDR_W | Write address on port A |
| wrDataA | input | 2*COMP_W | Write data on port A, real and imaginary parts packed |
| wrEnB | input | 1 | Write request on port B |
| wrAddrB | input | ADDR_W | Write address on port B |
| wrDataB | input | 2*COMP_W | Write data on port B |
| rdDataA | output | 2*COMP_W | Registered read data for port A |
| rdDataB | output | 2*COMP_W | Registered read data for port B |
| conflict | output | 1 | High in a cycle where two reads or two writes target the same bank |

## Verification
The assertions rely on the control and the datapath seeing the same request inputs in a given cycle. They also assume that a dropped or idle port's output register is changed only through the clock, so any hold can be checked one edge later. The stimulus applies each request for exactly one clock edge and then idles all enables. This keeps each vector's effect on the banks and the output registers isolated. Conflicting pairs are placed on purpose, some with equal indices and some with different ones, so that the priority of port A and the protection of port B's previous output can both be seen at the ports.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

  localparam int NUM_BANKS = 2;

  // Per-bank strobes from control to datapath; index 0 = even bank, 1 = odd bank.
  // Sel bits: 0 = port A owns the bank, 1 = port B owns it.
  typedef struct packed {
    logic [NUM_BANKS-1:0] rdEn;
    logic [NUM_BANKS-1:0] rdSel;
    logic [NUM_BANKS-1:0] wrEn;
    logic [NUM_BANKS-1:0] wrSel;
    logic                 rdDrop;
    logic                 wrDrop;
  } strobes_t;

endpackage

// File: rtl/dbc_ctrl.sv
module dbc_ctrl
  import dbc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rdEnA,
  input  logic     rdBankA,
  input  logic     rdEnB,
  input  logic     rdBankB,
  input  logic     wrEnA,
  input  logic     wrBankA,
  input  logic     wrEnB,
  input  logic     wrBankB,
  output strobes_t strobes
);

  logic rdClash;
  logic wrClash;

  assign rdClash = rdEnA && rdEnB && (rdBankA == rdBankB);
  assign wrClash = wrEnA && wrEnB && (wrBankA == wrBankB);

  always_comb begin
    strobes        = '0;
    strobes.rdDrop = rdClash;
    strobes.wrDrop = wrClash;
    for (int b = 0; b < NUM_BANKS; b++) begin
      logic aRd, bRd, aWr, bWr;
      aRd = rdEnA && (int'(rdBankA) == b);
      bRd = rdEnB && (int'(rdBankB) == b) && !rdClash;
      aWr = wrEnA && (int'(wrBankA) == b);
      bWr = wrEnB && (int'(wrBankB) == b) && !wrClash;
      strobes.rdEn[b]  = aRd || bRd;
      strobes.rdSel[b] = !aRd;
      strobes.wrEn[b]  = aWr || bWr;
      strobes.wrSel[b] = !aWr;
    end
  end

  // Split traffic never reports a drop.
  assert_split_no_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!(rdEnA && rdEnB && rdBankA == rdBankB) && !(wrEnA && wrEnB && wrBankA == wrBankB))
      |-> !(strobes.rdDrop || strobes.wrDrop));

  // Port A write always owns its bank.
  assert_port_a_write_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrEnA |-> (strobes.wrEn[wrBankA] && !strobes.wrSel[wrBankA]));

endmodule

// File: rtl/dbc_datapath.sv
module dbc_datapath
  import dbc_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int WORD_W  = 26,
  localparam int ADDR_W = $clog2(ENTRIES),
  localparam int DEPTH  = ENTRIES / NUM_BANKS,
  localparam int IDX_W  = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic              rdEnA,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic              rdEnB,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic [ADDR_W-1:0] wrAddrA,
  input  logic [WORD_W-1:0] wrDataA,
  input  logic [ADDR_W-1:0] wrAddrB,
  input  logic [WORD_W-1:0] wrDataB,
  output logic [WORD_W-1:0] rdDataA,
  output logic [WORD_W-1:0] rdDataB
);

  logic [WORD_W-1:0] bankRd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [WORD_W-1:0] store [DEPTH];
    logic [IDX_W-1:0]  rdIdx;
    logic [IDX_W-1:0]  wrIdx;
    logic [WORD_W-1:0] wrWord;

    assign rdIdx  = strobes.rdSel[b] ? rdAddrB[ADDR_W-1:1] : rdAddrA[ADDR_W-1:1];
    assign wrIdx  = strobes.wrSel[b] ? wrAddrB[ADDR_W-1:1] : wrAddrA[ADDR_W-1:1];
    assign wrWord = strobes.wrSel[b] ? wrDataB : wrDataA;

    always_comb bankRd[b] = store[rdIdx];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) store[i] <= '0;
      end else if (strobes.wrEn[b]) begin
        store[wrIdx] <= wrWord;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataA <= '0;
      rdDataB <= '0;
    end else begin
      if (rdEnA) rdDataA <= bankRd[rdAddrA[0]];
      if (rdEnB && !strobes.rdDrop) rdDataB <= bankRd[rdAddrB[0]];
    end
  end

  assert_drop_holds_b_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdDrop |=> $stable(rdDataB));

  assert_idle_holds_a_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rdEnA |=> $stable(rdDataA));

  assert_idle_holds_b_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rdEnB |=> $stable(rdDataB));

  initial assert_depth_even_R2: assert (ENTRIES % NUM_BANKS == 0 && ENTRIES >= 4);

endmodule

// File: rtl/dual_bank_cache.sv
module dual_bank_cache
  import dbc_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int COMP_W  = 13,
  localparam int ADDR_W = $clog2(ENTRIES),
  localparam int WORD_W = 2 * COMP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEnA,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic              rdEnB,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic              wrEnA,
  input  logic [ADDR_W-1:0] wrAddrA,
  input  logic [WORD_W-1:0] wrDataA,
  input  logic              wrEnB,
  input  logic [ADDR_W-1:0] wrAddrB,
  input  logic [WORD_W-1:0] wrDataB,
  output logic [WORD_W-1:0] rdDataA,
  output logic [WORD_W-1:0] rdDataB,
  output logic              conflict
);

  strobes_t strobes;

  dbc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rdEnA   (rdEnA),
    .rdBankA (rdAddrA[0]),
    .rdEnB   (rdEnB),
    .rdBankB (rdAddrB[0]),
    .wrEnA   (wrEnA),
    .wrBankA (wrAddrA[0]),
    .wrEnB   (wrEnB),
    .wrBankB (wrAddrB[0]),
    .strobes (strobes)
  );

  dbc_datapath #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rdEnA   (rdEnA),
    .rdAddrA (rdAddrA),
    .rdEnB   (rdEnB),
    .rdAddrB (rdAddrB),
    .wrAddrA (wrAddrA),
    .wrDataA (wrDataA),
    .wrAddrB (wrAddrB),
    .wrDataB (wrDataB),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB)
  );

  assign conflict = strobes.rdDrop || strobes.wrDrop;

endmodule

// File: tb/dual_bank_cache_tb.sv
module dual_bank_cache_tb;

  localparam int AW = 5;
  localparam int DW = 26;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rdEnA = 0, rdEnB = 0, wrEnA = 0, wrEnB = 0;
  logic [AW-1:0] rdAddrA = '0, rdAddrB = '0, wrAddrA = '0, wrAddrB = '0;
  logic [DW-1:0] wrDataA = '0, wrDataB = '0;
  logic [DW-1:0] rdDataA, rdDataB;
  logic          conflict;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  dual_bank_cache u_dut (
    .clk(clk), .rstN(rstN),
    .rdEnA(rdEnA), .rdAddrA(rdAddrA), .rdEnB(rdEnB), .rdAddrB(rdAddrB),
    .wrEnA(wrEnA), .wrAddrA(wrAddrA), .wrDataA(wrDataA),
    .wrEnB(wrEnB), .wrAddrB(wrAddrB), .wrDataB(wrDataB),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .conflict(conflict)
  );

  typedef struct packed {
    logic          rEA;  logic [AW-1:0] rAA;
    logic          rEB;  logic [AW-1:0] rAB;
    logic          wEA;  logic [AW-1:0] wAA; logic [DW-1:0] wDA;
    logic          wEB;  logic [AW-1:0] wAB; logic [DW-1:0] wDB;
    logic          xConf;
    logic [DW-1:0] xA;
    logic [DW-1:0] xB;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    // 0 R5 R10: split writes
    '{1'b0, 5'd0,  1'b0, 5'd0,  1'b1, 5'd4,  26'h0123456, 1'b1, 5'd7,  26'h0ABCDEF, 1'b0, 26'h0,       26'h0},
    // 1 R2 R3 R4: split reads
    '{1'b1, 5'd4,  1'b1, 5'd7,  1'b0, 5'd0,  26'h0,       1'b0, 5'd0,  26'h0,       1'b0, 26'h0123456, 26'h0ABCDEF},
    // 2 R2 R4: crossed ports
    '{1'b1, 5'd7,  1'b1, 5'd4,  1'b0, 5'd0,  26'h0,       1'b0, 5'd0,  26'h0,       1'b0, 26'h0ABCDEF, 26'h0123456},
    // 3 R8 write clash, R6 read of addr 10 returns old zero
    '{1'b1, 5'd10, 1'b1, 5'd3,  1'b1, 5'd10, 26'h1111111, 1'b1, 5'd12, 26'h2222222, 1'b1, 26'h0,       26'h0},
    // 4 R8 port A write landed
    '{1'b1, 5'd10, 1'b1, 5'd7,  1'b0, 5'd0,  26'h0,       1'b0, 5'd0,  26'h0,       1'b0, 26'h1111111, 26'h0ABCDEF},
    // 5 R7 read clash, R8 port B write dropped (12 still zero)
    '{1'b1, 5'd12, 1'b1, 5'd4,  1'b0, 5'd0,  26'h0,       1'b0, 5'd0,  26'h0,       1'b1, 26'h0,       26'h0ABCDEF},
    // 6 R6 same-address read/write, R9 idle port B holds
    '{1'b1, 5'd12, 1'b0, 5'd0,  1'b1, 5'd12, 26'h3333333, 1'b0, 5'd0,  26'h0,       1'b0, 26'h0,       26'h0ABCDEF},
    // 7 R3 new data visible
    '{1'b1, 5'd12, 1'b1, 5'd31, 1'b0, 5'd0,  26'h0,       1'b0, 5'd0,  26'h0,       1'b0, 26'h3333333, 26'h0},
    // 8 R5 R6 boundary addresses, reads see old values
    '{1'b1, 5'd31, 1'b1, 5'd0,  1'b1, 5'd0,  26'h0000001, 1'b1, 5'd31, 26'h3FFFFFF, 1'b0, 26'h0,       26'h0},
    // 9 R2 boundary readback
    '{1'b1, 5'd0,  1'b1, 5'd31, 1'b0, 5'd0,  26'h0,       1'b0, 5'd0,  26'h0,       1'b0, 26'h0000001, 26'h3FFFFFF},
    // 10 R8 same-address write clash
    '{1'b0, 5'd0,  1'b0, 5'd0,  1'b1, 5'd5,  26'h0555555, 1'b1, 5'd5,  26'h0666666, 1'b1, 26'h0000001, 26'h3FFFFFF},
    // 11 R8 port A value kept, R9 idle port A holds
    '{1'b0, 5'd0,  1'b1, 5'd5,  1'b0, 5'd0,  26'h0,       1'b0, 5'd0,  26'h0,       1'b0, 26'h0000001, 26'h0555555},
    // 12 R7 same-address read clash
    '{1'b1, 5'd13, 1'b1, 5'd13, 1'b0, 5'd0,  26'h0,       1'b0, 5'd0,  26'h0,       1'b1, 26'h0,       26'h0555555}
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    rdEnA = 0; rdEnB = 0; wrEnA = 0; wrEnB = 0;
  endtask

  task automatic apply(input vec_t v, input int idx);
    @(negedge clk);
    rdEnA = v.rEA; rdAddrA = v.rAA; rdEnB = v.rEB; rdAddrB = v.rAB;
    wrEnA = v.wEA; wrAddrA = v.wAA; wrDataA = v.wDA;
    wrEnB = v.wEB; wrAddrB = v.wAB; wrDataB = v.wDB;
    #1;
    check($sformatf("vec%0d conflict R7/R8/R10", idx), {25'd0, conflict}, {25'd0, v.xConf});
    @(posedge clk);
    #1 idle();
    @(negedge clk);
    check($sformatf("vec%0d rdDataA R2/R3/R6/R9", idx), rdDataA, v.xA);
    check($sformatf("vec%0d rdDataB R2/R3/R7/R9", idx), rdDataB, v.xB);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rdDataA at reset", rdDataA, '0);
    check("R1 rdDataB at reset", rdDataB, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 conflict idle", {25'd0, conflict}, '0);

    for (int i = 0; i < NV; i++) apply(VECS[i], i);

    // R1: reset mid-run clears stored data
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 rdDataA cleared", rdDataA, '0);
    check("R1 rdDataB cleared", rdDataB, '0);
    @(negedge clk);
    rstN = 1'b1;
    apply('{1'b1, 5'd4, 1'b1, 5'd31, 1'b0, 5'd0, 26'h0, 1'b0, 5'd0, 26'h0,
            1'b0, 26'h0, 26'h0}, 100);

    // R4 R10: reads split on parity while writes split too, all in one cycle
    apply('{1'b1, 5'd30, 1'b1, 5'd1, 1'b1, 5'd2, 26'h2AAAAAA, 1'b1, 5'd9, 26'h1555555,
            1'b0, 26'h0, 26'h0}, 101);
    apply('{1'b1, 5'd9, 1'b1, 5'd2, 1'b0, 5'd0, 26'h0, 1'b0, 5'd0, 26'h0,
            1'b0, 26'h1555555, 26'h2AAAAAA}, 102);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule